// File: doc/BRIEF.md
# Floppy Controller Command Sequencer

This block is the host-facing engine of a legacy floppy disk controller. The host exchanges bytes with it through a single byte-wide FIFO port and watches a main status byte to learn whether the port expects a write, offers a read, or is busy. Each command begins with an opcode byte. The sequencer knows how many parameter bytes each opcode takes and collects them. It then runs an execution step and offers the result bytes one at a time until the host has drained them.

The drive and the disk are reduced to a simple model. A media-present input stands in for the disk. Each drive's present cylinder is held in a register. Sector contents are a fixed pattern: each byte is the sector number XOR the low eight bits of the byte offset. When programmed I/O is selected (the DMA-enable input is low), a Read streams every sector byte through the FIFO before its results. An interrupt line marks the end of execution. The host clears it by draining results or by issuing Sense Interrupt.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After reset the status byte reads 0x80 (ready, host-to-controller) and the interrupt line is low.
- R2: The status byte reads 0x80 when idle, 0x90 while parameters are collected, 0x10 while executing, 0xF0 during the programmed-I/O data phase and 0xD0 during the result phase. Bit 7 means ready, bit 6 means controller-to-host, bit 5 means non-DMA data and bit 4 means busy. A FIFO write is taken only when bits 7:6 are 10, and a FIFO read only when they are 11. Any other write or read leaves the state unchanged.
- R3: The interrupt line stays low while parameters are being collected. Accepting any opcode drops a pending interrupt.
- R4: Opcode 0x08 (Sense Interrupt) with no seek completion pending returns the single byte 0x80.
- R5: Opcode 0x0F (Seek) takes the bytes head<<2|drive and cylinder, and has no result phase. On completion the status returns to 0x80 and the interrupt is raised. A following Sense Interrupt returns 0x20|head<<2|drive, then the cylinder, and leaves the interrupt low.
- R6: Opcode 0xE6 (Read) takes eight parameter bytes: drive/head, cylinder, head, first sector, size code, end-of-track sector, gap and data length. It yields seven result bytes: ST0, ST1, ST2, cylinder, head, last sector and size code. A normal ST0 is head<<2|drive with ST1 and ST2 zero. The interrupt rises as the result phase begins and falls on the first result read.
- R7: With the DMA-enable input low and media present, Read streams (last − first + 1) × (128 << size code) bytes with the status at 0xF0. Each byte is the sector number XOR the low byte of its offset.
- R8: A Read with no media present skips the data phase and enters the result phase at 0xD0. It returns ST0 0x40|head<<2|drive, ST1 0x01, and the first sector as the sector byte.
- R9: Any other opcode goes straight to a one-byte result of 0x80.
- R10: An end-of-track sector beyond the track length stops the transfer at the last sector on the track and reports ST0 0x40|hd, ST1 0x80. A first sector of 0, a first sector beyond the track, or an end below the first sector moves no data and reports ST0 0x40|hd, ST1 0x04.
- R11: With the DMA-enable input high, a Read with media present has no FIFO data phase and goes directly to the normal result bytes.
- R12: Opcode 0x0A (Read ID) takes one byte, head<<2|drive. It holds the status at 0x10 for a fixed number of cycles and then raises the interrupt. Its results are head<<2|drive, 0, 0, the drive's present cylinder, the head, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_wr | input | 1 | Host write strobe for the FIFO port |
| fifo_wdata | input | 8 | Byte written by the host |
| fifo_rd | input | 1 | Host read strobe for the FIFO port |
| fifo_rdata | output | 8 | Byte offered to the host (zero when nothing is offered) |
| msr | output | 8 | Main status byte |
| dma_en | input | 1 | High selects DMA transfer, low selects programmed I/O |
| media_in | input | 1 | Disk present in the drive |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the exact length of the programmed-I/O stream. A miscounted size code or sector range would leave the status at 0xF0 too long, or would start the result phase early, and the result bytes would land in the wrong reads. Result ordering after a Seek is also covered: a design that skipped the pending-seek flag would answer 0x80 instead of 0x20 and the cylinder. A write aimed at a result phase must not start a new command; a design that got this wrong would show 0x90 afterwards. The no-media, end-of-track overrun, bad start sector and DMA cases each need their own ST0 and ST1 codes, and a design that mixed up their priority would report the wrong pair.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

    // Opcodes recognised by the sequencer
    localparam logic [7:0] OPC_SENSE = 8'h08;
    localparam logic [7:0] OPC_SEEK  = 8'h0F;
    localparam logic [7:0] OPC_READ  = 8'hE6;
    localparam logic [7:0] OPC_RDID  = 8'h0A;

    // Status byte per phase (bit7 ready, bit6 to-host, bit5 non-DMA, bit4 busy)
    localparam logic [7:0] MSR_IDLE  = 8'h80;
    localparam logic [7:0] MSR_PARAM = 8'h90;
    localparam logic [7:0] MSR_EXEC  = 8'h10;
    localparam logic [7:0] MSR_PIO   = 8'hF0;
    localparam logic [7:0] MSR_RES   = 8'hD0;

    // Status-0 codes
    localparam logic [7:0] ST0_SEEK_END = 8'h20;
    localparam logic [7:0] ST0_ABNORMAL = 8'h40;
    localparam logic [7:0] ST0_INVALID  = 8'h80;

    localparam int PARAM_MAX = 8;
    localparam int RES_MAX   = 7;

    typedef enum logic [2:0] {PH_IDLE, PH_PARAM, PH_EXEC, PH_DATA, PH_RESULT} phase_e;
    typedef enum logic [2:0] {C_NONE, C_SENSE, C_SEEK, C_READ, C_RDID, C_BAD} cmd_e;

    // Result bytes, st0 first on the FIFO
    typedef struct packed {
        logic [7:0] st0;
        logic [7:0] st1;
        logic [7:0] st2;
        logic [7:0] cyl;
        logic [7:0] head;
        logic [7:0] sec;
        logic [7:0] size;
    } res7_t;

    function automatic cmd_e decode_op(input logic [7:0] op);
        case (op)
            OPC_SENSE: return C_SENSE;
            OPC_SEEK:  return C_SEEK;
            OPC_READ:  return C_READ;
            OPC_RDID:  return C_RDID;
            default:   return C_BAD;
        endcase
    endfunction

    function automatic logic [3:0] param_len(input cmd_e c);
        case (c)
            C_SEEK:  return 4'd2;
            C_READ:  return 4'd8;
            C_RDID:  return 4'd1;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic [7:0] pattern_byte(input logic [7:0] sec, input logic [7:0] off_lo);
        return sec ^ off_lo;
    endfunction

endpackage

// File: rtl/fdc_param_store.sv
module fdc_param_store #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  push,
    input  logic [7:0]            din,
    output logic [CW-1:0]         count,
    output logic [DEPTH-1:0][7:0] bytes_o
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (push) begin
            count <= count + 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [7:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (push && count == CW'(g)) begin
                slot_q <= din;
            end
        end
        assign bytes_o[g] = slot_q;
    end

endmodule

// File: rtl/fdc_xfer_ctr.sv
module fdc_xfer_ctr #(
    parameter int MAX_N = 3,
    parameter int OFF_W = 7 + MAX_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [7:0]       first_sec,
    input  logic [7:0]       last_sec,
    input  logic [7:0]       size_code,
    input  logic             advance,
    output logic [7:0]       cur_sec,
    output logic [OFF_W-1:0] offset,
    output logic             final_byte
);

    logic [2:0]       n_eff;
    logic [OFF_W-1:0] last_off;
    logic [7:0]       end_sec_q;
    logic             sec_end;

    // Size codes above the supported maximum are clamped
    always_comb begin
        n_eff    = (size_code > 8'(MAX_N)) ? 3'(MAX_N) : size_code[2:0];
        last_off = OFF_W'((128 << n_eff) - 1);
    end

    assign sec_end    = (offset == last_off);
    assign final_byte = advance && sec_end && (cur_sec == end_sec_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_sec   <= '0;
            end_sec_q <= '0;
            offset    <= '0;
        end else if (start) begin
            cur_sec   <= first_sec;
            end_sec_q <= last_sec;
            offset    <= '0;
        end else if (advance) begin
            if (sec_end) begin
                offset  <= '0;
                cur_sec <= cur_sec + 8'd1;
            end else begin
                offset <= offset + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fdc_res_buf.sv
module fdc_res_buf
    import fdc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  res7_t      load_val,
    input  logic [2:0] load_len,
    input  logic       pop,
    output logic [7:0] cur,
    output logic       at_last
);

    localparam logic [2:0] TOP_IDX = 3'(RES_MAX - 1);

    res7_t                     q;
    logic [RES_MAX-1:0][7:0]   arr;
    logic [2:0]                idx;
    logic [2:0]                len;
    logic [2:0]                sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            idx <= '0;
            len <= 3'd1;
        end else if (load) begin
            q   <= load_val;
            idx <= '0;
            len <= load_len;
        end else if (pop && !at_last) begin
            idx <= idx + 3'd1;
        end
    end

    assign arr     = q;
    assign sel     = TOP_IDX - idx;
    assign cur     = arr[sel];
    assign at_last = (idx == len - 3'd1);

endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
    import fdc_seq_pkg::*;
#(
    parameter int NUM_DRIVES        = 4,
    parameter int SECTORS_PER_TRACK = 18,
    parameter int MAX_SIZE_CODE     = 3,
    parameter int RDID_DELAY        = 40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_wr,
    input  logic [7:0] fifo_wdata,
    input  logic       fifo_rd,
    output logic [7:0] fifo_rdata,
    output logic [7:0] msr,
    input  logic       dma_en,
    input  logic       media_in,
    output logic       irq
);

    localparam int         P_CW  = $clog2(PARAM_MAX + 1);
    localparam int         DLY_W = $clog2(RDID_DELAY + 1);
    localparam int         OFF_W = 7 + MAX_SIZE_CODE;
    localparam logic [7:0] SPT   = 8'(SECTORS_PER_TRACK);

    phase_e                   phase;
    cmd_e                     cmd;
    cmd_e                     cmd_in;
    logic                     irq_q, seek_pend;
    logic [7:0]               seek_st0, seek_cyl;
    logic [DLY_W-1:0]         dly;
    logic [P_CW-1:0]          p_cnt;
    logic [PARAM_MAX-1:0][7:0] prm;

    logic wr_ok, rd_ok, op_accept, prm_push, params_full;
    logic seek_done, rdid_done, go_data, xfer_start, xfer_final;
    logic bad_range, overrun;
    logic [7:0] hd_st0, last_sec, rdid_cyl, xfer_sec;
    logic [OFF_W-1:0] xfer_off;
    logic [7:0] pcn [NUM_DRIVES];

    res7_t      read_res, rdid_res, res_val;
    logic [2:0] res_len;
    logic       res_load, res_last;
    logic [7:0] res_cur;

    // Host handshake gating
    assign wr_ok       = fifo_wr && (phase == PH_IDLE || phase == PH_PARAM);
    assign rd_ok       = fifo_rd && (phase == PH_DATA || phase == PH_RESULT);
    assign cmd_in      = decode_op(fifo_wdata);
    assign op_accept   = wr_ok && (phase == PH_IDLE);
    assign prm_push    = wr_ok && (phase == PH_PARAM);
    assign params_full = prm_push && ((p_cnt + 1'b1) == P_CW'(param_len(cmd)));

    fdc_param_store #(.DEPTH(PARAM_MAX), .CW(P_CW)) u_prm (
        .clk     (clk),
        .rst     (rst),
        .clear   (op_accept),
        .push    (prm_push),
        .din     (fifo_wdata),
        .count   (p_cnt),
        .bytes_o (prm)
    );

    // Read parameter analysis
    assign hd_st0    = {5'b0, prm[0][2:0]};
    assign bad_range = (prm[3] == 8'd0) || (prm[3] > SPT) || (prm[5] < prm[3]);
    assign overrun   = (prm[5] > SPT);
    assign last_sec  = overrun ? SPT : prm[5];
    assign go_data   = media_in && !dma_en && !bad_range;

    assign seek_done  = (phase == PH_EXEC) && (cmd == C_SEEK);
    assign rdid_done  = (phase == PH_EXEC) && (cmd == C_RDID) && (dly == DLY_W'(RDID_DELAY - 1));
    assign xfer_start = (phase == PH_EXEC) && (cmd == C_READ) && go_data;

    // Per-drive present cylinder registers
    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
        logic [7:0] cyl_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cyl_q <= '0;
            end else if (seek_done && prm[0][1:0] == 2'(d)) begin
                cyl_q <= prm[1];
            end
        end
        assign pcn[d] = cyl_q;
    end

    always_comb begin
        rdid_cyl = '0;
        for (int d = 0; d < NUM_DRIVES; d++) begin
            if (prm[0][1:0] == 2'(d)) rdid_cyl = pcn[d];
        end
    end

    fdc_xfer_ctr #(.MAX_N(MAX_SIZE_CODE), .OFF_W(OFF_W)) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .start      (xfer_start),
        .first_sec  (prm[3]),
        .last_sec   (last_sec),
        .size_code  (prm[4]),
        .advance    (rd_ok && phase == PH_DATA),
        .cur_sec    (xfer_sec),
        .offset     (xfer_off),
        .final_byte (xfer_final)
    );

    // Result assembly; checks run in priority: media, range, overrun
    always_comb begin
        read_res      = '0;
        read_res.st0  = hd_st0;
        read_res.cyl  = prm[1];
        read_res.head = prm[2];
        read_res.sec  = last_sec;
        read_res.size = prm[4];
        if (!media_in) begin
            read_res.st0 = ST0_ABNORMAL | hd_st0;
            read_res.st1 = 8'h01;
            read_res.sec = prm[3];
        end else if (bad_range) begin
            read_res.st0 = ST0_ABNORMAL | hd_st0;
            read_res.st1 = 8'h04;
            read_res.sec = prm[3];
        end else if (overrun) begin
            read_res.st0 = ST0_ABNORMAL | hd_st0;
            read_res.st1 = 8'h80;
        end
        rdid_res      = '0;
        rdid_res.st0  = hd_st0;
        rdid_res.cyl  = rdid_cyl;
        rdid_res.head = {7'b0, prm[0][2]};
        rdid_res.sec  = 8'd1;
        rdid_res.size = 8'd2;
    end

    always_comb begin
        res_val = '0;
        res_len = 3'(RES_MAX);
        case (phase)
            PH_IDLE: begin
                if (cmd_in == C_SENSE && seek_pend) begin
                    res_val.st0 = seek_st0;
                    res_val.st1 = seek_cyl;   // second byte carries the cylinder
                    res_len     = 3'd2;
                end else begin
                    res_val.st0 = ST0_INVALID;
                    res_len     = 3'd1;
                end
            end
            PH_EXEC: res_val = (cmd == C_RDID) ? rdid_res : read_res;
            default: res_val = read_res;
        endcase
    end

    assign res_load = (op_accept && param_len(cmd_in) == 4'd0)
                   || (phase == PH_EXEC && cmd == C_READ && !go_data)
                   || rdid_done
                   || (phase == PH_DATA && xfer_final);

    fdc_res_buf u_res (
        .clk      (clk),
        .rst      (rst),
        .load     (res_load),
        .load_val (res_val),
        .load_len (res_len),
        .pop      (rd_ok && phase == PH_RESULT),
        .cur      (res_cur),
        .at_last  (res_last)
    );

    // Phase sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cmd       <= C_NONE;
            irq_q     <= 1'b0;
            seek_pend <= 1'b0;
            seek_st0  <= '0;
            seek_cyl  <= '0;
            dly       <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (op_accept) begin
                    irq_q     <= 1'b0;
                    seek_pend <= 1'b0;
                    cmd       <= cmd_in;
                    phase     <= (param_len(cmd_in) == 4'd0) ? PH_RESULT : PH_PARAM;
                end
                PH_PARAM: if (params_full) begin
                    phase <= PH_EXEC;
                    dly   <= '0;
                end
                PH_EXEC: begin
                    case (cmd)
                        C_SEEK: begin
                            irq_q     <= 1'b1;
                            seek_pend <= 1'b1;
                            seek_st0  <= ST0_SEEK_END | hd_st0;
                            seek_cyl  <= prm[1];
                            phase     <= PH_IDLE;
                        end
                        C_READ: begin
                            if (go_data) begin
                                phase <= PH_DATA;
                            end else begin
                                phase <= PH_RESULT;
                                irq_q <= 1'b1;
                            end
                        end
                        C_RDID: begin
                            if (rdid_done) begin
                                phase <= PH_RESULT;
                                irq_q <= 1'b1;
                            end else begin
                                dly <= dly + 1'b1;
                            end
                        end
                        default: phase <= PH_IDLE;
                    endcase
                end
                PH_DATA: if (xfer_final) begin
                    phase <= PH_RESULT;
                    irq_q <= 1'b1;
                end
                PH_RESULT: if (rd_ok) begin
                    irq_q <= 1'b0;
                    if (res_last) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        case (phase)
            PH_IDLE:   msr = MSR_IDLE;
            PH_PARAM:  msr = MSR_PARAM;
            PH_EXEC:   msr = MSR_EXEC;
            PH_DATA:   msr = MSR_PIO;
            PH_RESULT: msr = MSR_RES;
            default:   msr = MSR_IDLE;
        endcase
        case (phase)
            PH_DATA:   fifo_rdata = pattern_byte(xfer_sec, xfer_off[7:0]);
            PH_RESULT: fifo_rdata = res_cur;
            default:   fifo_rdata = 8'h00;
        endcase
    end

    assign irq = irq_q;

endmodule

// File: rtl/fdc_cmd_seq_chk.sv
module fdc_cmd_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       fifo_wr,
    input logic       fifo_rd,
    input logic [7:0] msr,
    input logic       irq,
    input logic       dma_en,
    input logic       media_in
);

    p_msr_legal_r2: assert property (@(posedge clk) disable iff (rst)
        msr inside {8'h80, 8'h90, 8'h10, 8'hF0, 8'hD0});

    p_wr_in_result_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (msr == 8'hD0 && fifo_wr && !fifo_rd) |=> (msr == 8'hD0));

    p_irq_low_params_r3: assert property (@(posedge clk) disable iff (rst)
        (msr == 8'h90) |-> !irq);

    p_irq_rise_point_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (msr == 8'h80 || msr == 8'hD0));

    p_data_needs_media_pio_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(msr == 8'hF0) |-> ($past(media_in) && !$past(dma_en)));

    p_data_waits_host_r7: assert property (@(posedge clk) disable iff (rst)
        (msr == 8'hF0 && !fifo_rd) |=> (msr == 8'hF0));

endmodule

bind fdc_cmd_seq fdc_cmd_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .fifo_wr  (fifo_wr),
    .fifo_rd  (fifo_rd),
    .msr      (msr),
    .irq      (irq),
    .dma_en   (dma_en),
    .media_in (media_in)
);

// File: tb/tb_fdc_cmd_seq.sv
`timescale 1ns/1ps
module tb_fdc_cmd_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_wr = 1'b0;
    logic [7:0] fifo_wdata = 8'h00;
    logic       fifo_rd = 1'b0;
    logic [7:0] fifo_rdata;
    logic [7:0] msr;
    logic       dma_en = 1'b0;
    logic       media_in = 1'b0;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    fdc_cmd_seq dut (
        .clk        (clk),
        .rst        (rst),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata),
        .fifo_rd    (fifo_rd),
        .fifo_rdata (fifo_rdata),
        .msr        (msr),
        .dma_en     (dma_en),
        .media_in   (media_in),
        .irq        (irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Write one byte through the handshake (waits for ready, host-to-controller)
    task automatic send(input logic [7:0] b);
        int t = 0;
        while (msr[7:6] != 2'b10 && t < 200) begin @(negedge clk); t++; end
        chk("R2 write handshake", {8'h00, msr[7:6], 6'h0}, 16'h0080);
        fifo_wr = 1'b1; fifo_wdata = b;
        @(negedge clk);
        fifo_wr = 1'b0;
    endtask

    task automatic recv(output logic [7:0] b);
        int t = 0;
        while (msr[7:6] != 2'b11 && t < 200) begin @(negedge clk); t++; end
        chk("R2 read handshake", {8'h00, msr[7:6], 6'h0}, 16'h00C0);
        b = fifo_rdata;
        fifo_rd = 1'b1;
        @(negedge clk);
        fifo_rd = 1'b0;
    endtask

    task automatic expect_bytes(input string req, input logic [7:0] e [7], input int n);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            recv(v);
            chk(req, {8'h00, v}, {8'h00, e[i]});
        end
    endtask

    task automatic send_read(input logic [7:0] hd, c, h, r, n, eot);
        send(8'hE6); send(hd); chk("R3 irq low in params", {15'h0, irq}, 16'h0);
        send(c); send(h); send(r); send(n); send(eot); send(8'h1B); send(8'hFF);
    endtask

    task automatic t_reset();
        chk("R1 reset msr", {8'h00, msr}, 16'h0080);
        chk("R1 reset irq", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_sense_idle();
        logic [7:0] v;
        send(8'h08); recv(v);
        chk("R4 sense none pending", {8'h00, v}, 16'h0080);
        chk("R4 single byte result", {8'h00, msr}, 16'h0080);
    endtask

    task automatic t_seek();
        logic [7:0] v;
        send(8'h0F); send(8'h00);
        chk("R3 msr collecting", {8'h00, msr}, 16'h0090);
        chk("R3 irq low in params", {15'h0, irq}, 16'h0);
        send(8'h05); idle(2);
        chk("R5 seek no result", {8'h00, msr}, 16'h0080);
        chk("R5 seek irq raised", {15'h0, irq}, 16'h1);
        send(8'h08); recv(v);
        chk("R5 sense st0", {8'h00, v}, 16'h0020);
        recv(v);
        chk("R5 sense cylinder", {8'h00, v}, 16'h0005);
        chk("R5 irq dropped", {15'h0, irq}, 16'h0);
        chk("R5 back to idle", {8'h00, msr}, 16'h0080);
    endtask

    task automatic t_read_id();
        logic [7:0] e [7];
        int t = 0;
        send(8'h0F); send(8'h04); send(8'h08); idle(2);
        chk("R5 seek head1 irq", {15'h0, irq}, 16'h1);
        send(8'h0A);
        chk("R3 opcode drops irq", {15'h0, irq}, 16'h0);
        send(8'h04);
        chk("R12 busy during read id", {8'h00, msr}, 16'h0010);
        idle(20);
        chk("R12 still busy", {8'h00, msr}, 16'h0010);
        while (!irq && t < 200) begin @(negedge clk); t++; end
        chk("R12 irq after delay", {15'h0, irq}, 16'h1);
        e = '{8'h04, 8'h00, 8'h00, 8'h08, 8'h01, 8'h01, 8'h02};
        expect_bytes("R12 read id result", e, 7);
        chk("R12 back to idle", {8'h00, msr}, 16'h0080);
    endtask

    task automatic t_bad_op();
        logic [7:0] v;
        send(8'h55); recv(v);
        chk("R9 invalid opcode", {8'h00, v}, 16'h0080);
        chk("R9 one byte", {8'h00, msr}, 16'h0080);
    endtask

    task automatic t_ignored();
        logic [7:0] v;
        send(8'h08); idle(1);
        chk("R2 result phase msr", {8'h00, msr}, 16'h00D0);
        fifo_wr = 1'b1; fifo_wdata = 8'h0F; @(negedge clk); fifo_wr = 1'b0;
        chk("R2 write in result ignored", {8'h00, msr}, 16'h00D0);
        recv(v);
        chk("R2 result intact", {8'h00, v}, 16'h0080);
        chk("R2 no new command", {8'h00, msr}, 16'h0080);
        fifo_rd = 1'b1; @(negedge clk); fifo_rd = 1'b0;
        chk("R2 read in idle ignored", {8'h00, msr}, 16'h0080);
    endtask

    task automatic t_read_nomedia();
        logic [7:0] e [7];
        logic [7:0] v;
        media_in = 1'b0; dma_en = 1'b0;
        send_read(8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h01); idle(2);
        chk("R8 msr at result", {8'h00, msr}, 16'h00D0);
        chk("R6 irq at result", {15'h0, irq}, 16'h1);
        recv(v);
        chk("R8 st0 no media", {8'h00, v}, 16'h0040);
        chk("R6 irq cleared by read", {15'h0, irq}, 16'h0);
        e = '{8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h00};
        expect_bytes("R8 remaining result", e, 6);
        chk("R6 seven bytes then idle", {8'h00, msr}, 16'h0080);
    endtask

    task automatic pull_data(input string req, input logic [7:0] first, input int nsec, input int bytes_per);
        logic [7:0] v;
        for (int s = 0; s < nsec; s++) begin
            for (int o = 0; o < bytes_per; o++) begin
                chk({req, " msr pio"}, {8'h00, msr}, 16'h00F0);
                recv(v);
                chk({req, " data byte"}, {8'h00, v}, {8'h00, (first + 8'(s)) ^ 8'(o)});
            end
        end
    endtask

    task automatic t_read_pio();
        logic [7:0] e [7];
        media_in = 1'b1; dma_en = 1'b0;
        send_read(8'h05, 8'h03, 8'h01, 8'h01, 8'h00, 8'h02); idle(2);
        pull_data("R7", 8'h01, 2, 128);
        chk("R7 result after exact count", {8'h00, msr}, 16'h00D0);
        e = '{8'h05, 8'h00, 8'h00, 8'h03, 8'h01, 8'h02, 8'h00};
        expect_bytes("R6 read result", e, 7);
    endtask

    task automatic t_read_overrun();
        logic [7:0] e [7];
        media_in = 1'b1; dma_en = 1'b0;
        send_read(8'h00, 8'h00, 8'h00, 8'd17, 8'h01, 8'd19); idle(2);
        pull_data("R10", 8'd17, 2, 256);
        chk("R10 stops at track end", {8'h00, msr}, 16'h00D0);
        e = '{8'h40, 8'h80, 8'h00, 8'h00, 8'h00, 8'd18, 8'h01};
        expect_bytes("R10 overrun result", e, 7);
    endtask

    task automatic t_read_badstart();
        logic [7:0] e [7];
        media_in = 1'b1; dma_en = 1'b0;
        send_read(8'h01, 8'h02, 8'h00, 8'h00, 8'h02, 8'h03); idle(2);
        chk("R10 no data for sector 0", {8'h00, msr}, 16'h00D0);
        e = '{8'h41, 8'h04, 8'h00, 8'h02, 8'h00, 8'h00, 8'h02};
        expect_bytes("R10 bad start result", e, 7);
    endtask

    task automatic t_read_dma();
        logic [7:0] e [7];
        media_in = 1'b1; dma_en = 1'b1;
        send_read(8'h00, 8'h07, 8'h00, 8'h03, 8'h02, 8'h05); idle(2);
        chk("R11 no fifo data in dma", {8'h00, msr}, 16'h00D0);
        e = '{8'h00, 8'h00, 8'h00, 8'h07, 8'h00, 8'h05, 8'h02};
        expect_bytes("R11 dma result", e, 7);
        dma_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sense_idle();
        t_seek();
        t_read_id();
        t_bad_op();
        t_ignored();
        t_read_nomedia();
        t_read_pio();
        t_read_overrun();
        t_read_badstart();
        t_read_dma();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule